// File: doc/BRIEF.md
# Dual-Class Interrupt Priority Sorter

This block chooses one winning interrupt line out of one or three banks of 32 lines. Each line carries a pending bit, a mask bit, a class-steering bit and a small priority number. The steering bit sends a pending line to one of two delivery classes: the normal class or the fast class. A caller picks one class, pulses `start`, and after a fixed number of cycles gets back the code of the most urgent unmasked pending line in that class, with a one-cycle `done` strobe.

The sorter walks the lines one per clock. It keeps a running best line, so the logic per cycle stays small whatever the line count. Two any-pending flags, one for each class, are formed combinationally from the live inputs. An upstream controller can use them to decide whether a sort is worth starting at all. The caller holds the line inputs stable from the accepted start until `done`.

Top module: `prio_sorter_top`

## Requirements
- R1: A line is a candidate for a class only when it is pending, its mask bit is 0, and its steering bit matches that class (steering 1 selects the fast class, 0 the normal class). `cls_sel` = 1 requests the fast class.
- R2: Among candidates, the smallest priority number wins; 0 is the most urgent.
- R3: When several candidates share the best priority, the one with the highest global line number wins.
- R4: The code reported is 32 × bank + bit position, i.e. the global line index, where line i is bit i of each line vector and priority bits [i*PW +: PW] of `prio_flat`.
- R5: When no line is a candidate for the requested class, the code is 0.
- R6: A start accepted at a clock edge gives `done` high for exactly one cycle, N edges later (N = 32 × bank count). `busy` is high between the two. `code` changes only when `done` rises and holds its value until then.
- R7: A `start` seen while `busy` is high is ignored: it neither restarts the sort, changes the class nor moves the `done` timing.
- R8: `any_norm` and `any_fast` are, in the same cycle, the OR of all candidate bits of the normal class and the fast class respectively.
- R9: After synchronous reset, `busy`, `done` and `code` are all 0.
- R10: The priority field is 5 bits wide with one bank and 6 bits with three banks. All of its bits take part in the comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a sort; taken only while idle |
| cls_sel | input | 1 | Class to sort, sampled with an accepted start (1 = fast) |
| pending | input | N | Pending bit per line |
| mask | input | N | Mask bit per line (1 = blocked) |
| steer | input | N | Class steering per line (1 = fast) |
| prio_flat | input | N × PW | Priority number per line, line i at [i*PW +: PW] |
| busy | output | 1 | Sort in progress |
| done | output | 1 | One-cycle strobe when `code` is updated |
| code | output | log2(N) | Winning global line index, 0 if none |
| any_norm | output | 1 | Some normal-class candidate exists |
| any_fast | output | 1 | Some fast-class candidate exists |

## Verification
A corrupted scan index or running-best record stays hidden until the end of the walk. It then shows as a wrong `code` at the `done` edge, N cycles after the start, so the bench checks every result against a freshly computed winner. A wrong sequencer state shows at once as `busy` or `done` out of step with a cycle count kept outside the design, and this is compared every clock. The class flags have no state, so a fault in the candidate stage shows in `any_norm` and `any_fast` in the same cycle the inputs change. It also changes the winner of the next sort.

// File: rtl/isort_pkg.sv
package isort_pkg;

    localparam int BANK_LINES = 32;
    localparam int MAX_PRIO_W = 6;
    localparam int MAX_LINE_W = 7;

    typedef enum logic {
        CLS_NORM = 1'b0,
        CLS_FAST = 1'b1
    } cls_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;

    typedef struct packed {
        logic                  hit;
        logic [MAX_PRIO_W-1:0] prio;
        logic [MAX_LINE_W-1:0] line;
    } best_t;

    function automatic int prio_width(input int banks);
        return (banks == 1) ? 5 : 6;
    endfunction

    // Lines are visited in ascending order, so "<=" hands ties to the later (higher) line.
    function automatic best_t take_if_better(input best_t cur,
                                             input logic cand,
                                             input logic [MAX_PRIO_W-1:0] p,
                                             input logic [MAX_LINE_W-1:0] line);
        best_t nxt;
        nxt = cur;
        if (cand && (!cur.hit || (p <= cur.prio))) begin
            nxt.hit  = 1'b1;
            nxt.prio = p;
            nxt.line = line;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/isort_cand.sv
module isort_cand
    import isort_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int N = NUM_BANKS * BANK_LINES
) (
    input  logic [N-1:0] pending,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] steer,
    output logic [N-1:0] cand_norm,
    output logic [N-1:0] cand_fast,
    output logic         any_norm,
    output logic         any_fast
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_LINES-1:0] live;
        assign live = pending[b*BANK_LINES +: BANK_LINES] & ~mask[b*BANK_LINES +: BANK_LINES];
        assign cand_norm[b*BANK_LINES +: BANK_LINES] = live & ~steer[b*BANK_LINES +: BANK_LINES];
        assign cand_fast[b*BANK_LINES +: BANK_LINES] = live &  steer[b*BANK_LINES +: BANK_LINES];
    end

    assign any_norm = |cand_norm;
    assign any_fast = |cand_fast;

endmodule

// File: rtl/isort_step.sv
module isort_step
    import isort_pkg::*;
(
    input  best_t                 cur,
    input  logic                  cand,
    input  logic [MAX_PRIO_W-1:0] prio,
    input  logic [MAX_LINE_W-1:0] line,
    output best_t                 nxt
);

    always_comb begin
        nxt = take_if_better(cur, cand, prio, line);
    end

endmodule

// File: rtl/isort_seq.sv
module isort_seq
    import isort_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int N      = NUM_BANKS * BANK_LINES,
    localparam int PW     = prio_width(NUM_BANKS),
    localparam int IDX_W  = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cls_sel,
    input  logic [N-1:0]     cand_norm,
    input  logic [N-1:0]     cand_fast,
    input  logic [N*PW-1:0]  prio_flat,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] code
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    scan_st_e         st_q;
    cls_e             cls_q;
    logic [IDX_W-1:0] idx_q;
    best_t            best_q;
    best_t            best_nxt;
    logic             cand_bit;
    logic [PW-1:0]    prio_cur;

    always_comb begin
        cand_bit = (cls_q == CLS_FAST) ? cand_fast[idx_q] : cand_norm[idx_q];
        prio_cur = prio_flat[int'(idx_q)*PW +: PW];
    end

    isort_step u_step (
        .cur  (best_q),
        .cand (cand_bit),
        .prio (MAX_PRIO_W'(prio_cur)),
        .line (MAX_LINE_W'(idx_q)),
        .nxt  (best_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cls_q  <= CLS_NORM;
            idx_q  <= '0;
            best_q <= '0;
            done   <= 1'b0;
            code   <= '0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_SCAN;
                        cls_q  <= cls_e'(cls_sel);
                        idx_q  <= '0;
                        best_q <= '0;
                    end
                end
                ST_SCAN: begin
                    best_q <= best_nxt;
                    if (idx_q == LAST) begin
                        st_q <= ST_IDLE;
                        done <= 1'b1;
                        code <= best_nxt.hit ? best_nxt.line[IDX_W-1:0] : '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st_q == ST_SCAN);

endmodule

// File: rtl/prio_sorter_top.sv
module prio_sorter_top
    import isort_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int N      = NUM_BANKS * BANK_LINES,
    localparam int PW     = prio_width(NUM_BANKS),
    localparam int CODE_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cls_sel,
    input  logic [N-1:0]      pending,
    input  logic [N-1:0]      mask,
    input  logic [N-1:0]      steer,
    input  logic [N*PW-1:0]   prio_flat,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] code,
    output logic              any_norm,
    output logic              any_fast
);

    logic [N-1:0] cand_norm;
    logic [N-1:0] cand_fast;

    isort_cand #(.NUM_BANKS(NUM_BANKS)) u_cand (
        .pending   (pending),
        .mask      (mask),
        .steer     (steer),
        .cand_norm (cand_norm),
        .cand_fast (cand_fast),
        .any_norm  (any_norm),
        .any_fast  (any_fast)
    );

    isort_seq #(.NUM_BANKS(NUM_BANKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cls_sel   (cls_sel),
        .cand_norm (cand_norm),
        .cand_fast (cand_fast),
        .prio_flat (prio_flat),
        .busy      (busy),
        .done      (done),
        .code      (code)
    );

endmodule

// File: rtl/prio_sorter_chk.sv
module prio_sorter_chk #(
    parameter int N      = 96,
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [N-1:0]      pending,
    input logic [N-1:0]      mask,
    input logic [N-1:0]      steer,
    input logic              busy,
    input logic              done,
    input logic [CODE_W-1:0] code,
    input logic              any_norm,
    input logic              any_fast
);

    localparam int CNT_W = $clog2(N + 1) + 1;

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    // R6: the strobe lands exactly N edges after acceptance
    p_done_latency_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == CNT_W'(N)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_code_hold_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (done || $stable(code)));

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && (busy_cnt != CNT_W'(N - 1))) |=> busy);

    // R7: an idle start is always taken
    p_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R4: reported code is a real line index
    p_code_range_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(code) < N));

    // R1: nothing unmasked and pending means no class has a candidate
    p_no_live_r1: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~mask) == '0) |-> (!any_norm && !any_fast));

    // R8: a fast flag needs some fast-steered live line
    p_fast_src_r8: assert property (@(posedge clk) disable iff (rst)
        any_fast |-> ((pending & ~mask & steer) != '0));

    p_norm_src_r8: assert property (@(posedge clk) disable iff (rst)
        any_norm |-> ((pending & ~mask & ~steer) != '0));

endmodule

bind prio_sorter_top prio_sorter_chk #(.N(N), .CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pending  (pending),
    .mask     (mask),
    .steer    (steer),
    .busy     (busy),
    .done     (done),
    .code     (code),
    .any_norm (any_norm),
    .any_fast (any_fast)
);

// File: tb/prio_sorter_top_tb_top.sv
module prio_sorter_top_tb_top;

    localparam int NB = 3;
    localparam int N  = NB * 32;
    localparam int PW = 6;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cls_sel = 1'b0;
    logic [N-1:0]  pending = '0;
    logic [N-1:0]  mask = '0;
    logic [N-1:0]  steer = '0;
    logic [N*PW-1:0] prio_flat = '0;
    logic          busy;
    logic          done;
    logic [CW-1:0] code;
    logic          any_norm;
    logic          any_fast;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // model state
    bit m_busy = 0;
    bit m_done = 0;
    int m_cnt = 0;
    int m_code = 0;
    bit m_cls = 0;

    always #2.5 clk = ~clk;

    prio_sorter_top #(.NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst(rst), .start(start), .cls_sel(cls_sel),
        .pending(pending), .mask(mask), .steer(steer), .prio_flat(prio_flat),
        .busy(busy), .done(done), .code(code),
        .any_norm(any_norm), .any_fast(any_fast)
    );

    function automatic bit is_cand(int i, bit cls);
        return pending[i] && !mask[i] && (steer[i] == cls);
    endfunction

    function automatic int prio_of(int i);
        return int'(prio_flat[i*PW +: PW]);
    endfunction

    // scans from the top down; strict compare keeps the higher line on ties (R3)
    function automatic int ref_pick(bit cls);
        int win = 0;
        int bp = 1000;
        for (int i = N - 1; i >= 0; i--) begin
            if (is_cand(i, cls) && prio_of(i) < bp) begin
                bp = prio_of(i);
                win = i;
            end
        end
        return win;
    endfunction

    function automatic bit ref_any(bit cls);
        bit a = 0;
        for (int i = 0; i < N; i++) a |= is_cand(i, cls);
        return a;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle model, inputs settle 1 time unit after each edge
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_code = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == N) begin
                    m_busy = 0;
                    m_done = 1;
                    m_code = ref_pick(m_cls);
                end
            end else if (start) begin
                m_busy = 1;
                m_cnt = 0;
                m_cls = cls_sel;
            end
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            check("R6", "busy", int'(busy), int'(m_busy));
            check("R6", "done", int'(done), int'(m_done));
            check("R2 R3 R4 R5", "code", int'(code), m_code);
            check("R8", "any_norm", int'(any_norm), int'(ref_any(1'b0)));
            check("R8", "any_fast", int'(any_fast), int'(ref_any(1'b1)));
        end
    end

    task automatic set_prio(int line, int val);
        prio_flat[line*PW +: PW] = PW'(val);
    endtask

    task automatic clear_all();
        @(posedge clk); #1;
        pending = '0; mask = '0; steer = '0; prio_flat = '0;
    endtask

    task automatic sort(bit cls);
        @(posedge clk); #1;
        start = 1'b1; cls_sel = cls;
        @(posedge clk); #1;
        start = 1'b0;
        for (int k = 0; k < N + 4 && !done; k++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R9: reset state
        check("R9", "busy", int'(busy), 0);
        check("R9", "done", int'(done), 0);
        check("R9", "code", int'(code), 0);
        rst = 1'b0;

        // R5: everything pending but masked
        clear_all();
        pending = '1; mask = '1;
        sort(1'b0);
        sort(1'b1);

        // R2: lowest number wins across banks
        clear_all();
        pending[5] = 1; set_prio(5, 3);
        pending[70] = 1; set_prio(70, 1);
        pending[10] = 1; set_prio(10, 2);
        sort(1'b0);
        check("R2", "winner", int'(code), 70);

        // R3: ties go to the highest line
        clear_all();
        pending[3] = 1; pending[40] = 1; pending[90] = 1;
        set_prio(3, 4); set_prio(40, 4); set_prio(90, 4);
        sort(1'b0);
        check("R3", "tie winner", int'(code), 90);
        clear_all();
        pending[1] = 1; pending[31] = 1;
        sort(1'b0);
        check("R3", "bank0 tie", int'(code), 31);

        // R1 and R4: steering splits one pending set, masking removes lines
        clear_all();
        pending[33] = 1; steer[33] = 1; set_prio(33, 2);
        pending[64] = 1; steer[64] = 0; set_prio(64, 9);
        pending[95] = 1; steer[95] = 1; mask[95] = 1; set_prio(95, 0);
        pending[12] = 1; steer[12] = 0; mask[12] = 1; set_prio(12, 0);
        sort(1'b1);
        check("R1", "fast winner", int'(code), 33);
        sort(1'b0);
        check("R4", "normal winner", int'(code), 64);

        // R10: upper priority bit takes part in the compare
        clear_all();
        pending[20] = 1; set_prio(20, 40);
        pending[50] = 1; set_prio(50, 33);
        sort(1'b0);
        check("R10", "six-bit compare", int'(code), 50);
        clear_all();
        pending[80] = 1; set_prio(80, 32);
        pending[2] = 1; set_prio(2, 31);
        sort(1'b0);
        check("R10", "bit5 weight", int'(code), 2);

        // R7: a second start mid-sort with the other class is ignored
        clear_all();
        pending[7] = 1; steer[7] = 0;
        pending[60] = 1; steer[60] = 1;
        @(posedge clk); #1; start = 1'b1; cls_sel = 1'b0;
        @(posedge clk); #1; start = 1'b0;
        repeat (10) @(posedge clk);
        #1; start = 1'b1; cls_sel = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        for (int k = 0; k < N + 4 && !done; k++) @(negedge clk);
        check("R7", "class kept", int'(code), 7);
        @(negedge clk);

        // mixed patterns for every requirement path
        for (int t = 0; t < 24; t++) begin
            clear_all();
            for (int i = 0; i < N; i++) begin
                pending[i] = ($urandom % 3) != 0;
                mask[i]    = ($urandom % 4) == 0;
                steer[i]   = $urandom % 2;
                set_prio(i, (t % 3 == 0) ? ($urandom % 3) : ($urandom % 64));
            end
            sort(t[0]);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule